// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel

This block is one DMA channel that moves 16-bit audio samples between system memory and a small sample FIFO shared with a codec. Software places a chain of descriptors in memory. Each descriptor is three 32-bit words: a buffer address, a count word, and the address of the next descriptor. Software writes the address of the first descriptor into a pointer register and then writes a control word. The control word selects the direction, the window of the shared FIFO that this channel may use, and a high-water mark.

The channel reads a descriptor and moves that descriptor's bytes one halfword at a time. When the count runs out, it can raise an interrupt, and it then follows the next pointer. If the last descriptor points back to the first, the ring runs until software stops it. On the memory side there is a request/acknowledge port that has at most one access open at a time. A read-only register gives the memory address the channel is currently working on.

In transmit, the channel reads memory while the FIFO holds fewer halfwords than the mark and the window still has room. In receive, the channel writes memory while the FIFO holds at least the mark.

Top module: `audio_dma_chan`

## Requirements
- R1: After reset the control register reads 0, the buffer-address register reads 0, the interrupt output is low, no memory request is raised, and the FIFO level is 0.
- R2: A descriptor is fetched as three 32-bit reads at the descriptor address, then +4, then +8. These give, in order, the buffer address, the count word and the next-descriptor address. A request is held with a stable address until it is acknowledged.
- R3: In transmit (control bit 2 = 0), the halfwords read from each buffer reach the codec side of the FIFO in address order.
- R4: In transmit, the channel requests data only while the FIFO level, counted in halfwords, is below the high-water field (control bits 15:8). With no codec reads, the level settles at the mark and memory traffic stops.
- R5: In receive (control bit 2 = 1), the channel writes a halfword to memory only while the FIFO level is at least the mark. Halfwords go to consecutive buffer addresses in the order they were received.
- R6: When the count (bits 13:0 of the count word) of a descriptor whose interrupt-enable bit (bit 31) is set runs out, the interrupt output is raised. A descriptor with that bit clear never raises it.
- R7: The interrupt status stays set until software writes the control register (address 0). It is returned as bit 0 when the control register is read.
- R8: The next-descriptor word is followed without limit. A ring whose last descriptor points back to the first repeats its buffers in order.
- R9: A control write with the active bit (bit 4) clear stops the channel. Once any open access finishes, no further memory request is made. A control write with bit 4 set clears the FIFO and restarts the channel from the pointer register (address 1).
- R10: Register address 2 reads the memory address of the halfword the channel is transferring or waiting to transfer.
- R11: The FIFO window spans (end − begin) × 4 halfwords. Begin is in control bits 23:16 and end is in bits 31:24, both counted in 64-bit doublewords. The level never exceeds the window size, even when the mark is larger than the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 descriptor pointer, 2 buffer address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = halfword write, 0 = read |
| mem_wide | output | 1 | 1 = 32-bit descriptor read, 0 = halfword access |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 16 | Halfword to write |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data (halfword reads in bits 15:0) |
| smp_pop | input | 1 | Codec takes one halfword (transmit) |
| smp_rd_data | output | 16 | Oldest halfword in the FIFO |
| smp_push | input | 1 | Codec delivers one halfword (receive) |
| smp_wr_data | input | 16 | Halfword delivered by the codec |
| smp_level | output | LW | FIFO occupancy in halfwords |
| irq | output | 1 | Interrupt status |

## Verification
The state that is hardest to reach is a control write that arrives while a memory access is still open. The channel has to finish that access, discard its result, and restart cleanly. The stimulus reaches it by reprogramming the channel in the middle of transmit traffic and by stopping it while requests are flowing; each time it checks that the restarted stream begins again at the first buffer's first halfword. A second hard corner is a mark larger than the window. The stimulus reaches it with a one-doubleword window and a mark of 16, then checks that the level stops at four and the memory port goes quiet. Sample values and codec pacing come from a seeded random source.

// File: rtl/adma_pkg.sv
// Shared constants and types for the descriptor-ring audio DMA channel.
// Assumes a 32-bit control word and a three-word descriptor layout.
package adma_pkg;
    localparam int CTL_LOAD = 1;
    localparam int CTL_RECV = 2;
    localparam int CTL_RT   = 3;
    localparam int CTL_ACT  = 4;
    localparam int HW_LSB   = 8;
    localparam int BEG_LSB  = 16;
    localparam int END_LSB  = 24;
    localparam int DESC_IE  = 31;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DBUF, ST_DCNT, ST_DNXT, ST_XFER, ST_DONE
    } eng_st_t;
endpackage

// File: rtl/adma_regs.sv
// Host register file: control word, descriptor pointer, interrupt status.
// Assumes single-cycle writes; reads are combinational on addr.
module adma_regs #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [31:0]   wdata,
    input  logic          irq_set,
    input  logic [AW-1:0] cur_addr,
    output logic [31:0]   rdata,
    output logic [7:0]    hw_mark,
    output logic [7:0]    beg_dw,
    output logic [7:0]    end_dw,
    output logic          recv,
    output logic [AW-1:0] desc_ptr,
    output logic          irq,
    output logic          start,
    output logic          stop
);
    import adma_pkg::*;

    logic [31:1] ctrl_q;
    logic        ctl_wr;
    logic        unused_bit0;

    assign ctl_wr      = wr && (addr == 2'd0);
    assign start       = ctl_wr && wdata[CTL_ACT];
    assign stop        = ctl_wr && !wdata[CTL_ACT];
    assign hw_mark     = ctrl_q[HW_LSB+7:HW_LSB];
    assign beg_dw      = ctrl_q[BEG_LSB+7:BEG_LSB];
    assign end_dw      = ctrl_q[END_LSB+7:END_LSB];
    assign recv        = ctrl_q[CTL_RECV];
    assign unused_bit0 = wdata[0];

    // Register updates: control write clears status, otherwise engine may set it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            desc_ptr <= '0;
            irq      <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctrl_q <= wdata[31:1];
                irq    <= 1'b0;
            end else if (irq_set) begin
                irq <= 1'b1;
            end
            if (wr && addr == 2'd1) desc_ptr <= wdata[AW-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            2'd0:    rdata = {ctrl_q, irq};
            2'd1:    rdata = 32'(desc_ptr);
            2'd2:    rdata = 32'(cur_addr);
            default: rdata = '0;
        endcase
    end

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ctl_wr |=> irq);
    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !irq);
endmodule

// File: rtl/adma_winfifo.sv
// Sample FIFO confined to a window of shared storage given in doublewords.
// Assumes begin*4 + window size fits in DEPTH; clear empties it.
module adma_winfifo #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [7:0]    beg_dw,
    input  logic [7:0]    end_dw,
    input  logic          push,
    input  logic [15:0]   wdata,
    input  logic          pop,
    output logic [15:0]   rdata,
    output logic [LW-1:0] level,
    output logic          room
);
    logic [15:0]   store [DEPTH];
    logic [9:0]    base_hw, cap_raw;
    logic [LW-1:0] cap, rd_off, wr_off;
    logic [PW-1:0] ridx, widx;
    logic          push_ok, pop_ok;

    // Window size and physical indices.
    always_comb begin
        base_hw = {beg_dw, 2'b00};
        cap_raw = (end_dw > beg_dw) ? {end_dw - beg_dw, 2'b00} : 10'd0;
        cap     = (cap_raw > 10'(DEPTH)) ? LW'(DEPTH) : cap_raw[LW-1:0];
        ridx    = PW'(base_hw + 10'(rd_off));
        widx    = PW'(base_hw + 10'(wr_off));
        room    = level < cap;
        push_ok = push && room;
        pop_ok  = pop && (level != '0);
        rdata   = store[ridx];
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_off <= '0;
            wr_off <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_off <= (wr_off + 1'b1 == cap) ? '0 : wr_off + 1'b1;
            if (pop_ok)  rd_off <= (rd_off + 1'b1 == cap) ? '0 : rd_off + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    // Sample storage.
    always_ff @(posedge clk) begin
        if (push_ok && !clear) store[widx] <= wdata;
    end

    p_level_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap);
    p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level == '0 && !push |=> level == '0);
endmodule

// File: rtl/adma_engine.sv
// Descriptor walker and halfword transfer loop with one open memory access.
// Assumes even byte counts; commands are applied once no access is open.
module adma_engine #(
    parameter int AW = 16,
    parameter int CW = 14,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [AW-1:0] desc_ptr,
    input  logic          recv,
    input  logic [7:0]    hw_mark,
    input  logic [LW-1:0] fifo_level,
    input  logic          fifo_room,
    input  logic [15:0]   fifo_rdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          fifo_push,
    output logic          fifo_pop,
    output logic          irq_set,
    output logic [AW-1:0] cur_addr
);
    import adma_pkg::*;

    eng_st_t       st;
    logic [AW-1:0] dptr, buf_a;
    logic [CW-1:0] remain;
    logic          ie, busy_q, cmd_pend, cmd_go, dir_q;
    logic          want, apply, took, last_hw;
    logic [8:0]    lvl9;
    logic          unused_bits;

    assign unused_bits = ^mem_rdata[30:AW];
    assign lvl9        = 9'(fifo_level);
    assign last_hw     = remain <= CW'(2);
    assign cur_addr    = buf_a;
    assign mem_wdata   = fifo_rdata;

    // Request generation and address selection by state.
    always_comb begin
        want = dir_q ? (lvl9 >= {1'b0, hw_mark} && fifo_level != '0)
                     : (fifo_room && lvl9 < {1'b0, hw_mark});
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_wide = 1'b1;
        mem_addr = dptr;
        case (st)
            ST_DBUF: mem_req = 1'b1;
            ST_DCNT: begin mem_req = 1'b1; mem_addr = dptr + AW'(4); end
            ST_DNXT: begin mem_req = 1'b1; mem_addr = dptr + AW'(8); end
            ST_XFER: begin
                mem_req  = busy_q || want;
                mem_we   = dir_q;
                mem_wide = 1'b0;
                mem_addr = buf_a;
            end
            default: ;
        endcase
        apply     = cmd_pend && (!mem_req || mem_ack);
        took      = mem_req && mem_ack && !apply;
        fifo_push = took && st == ST_XFER && !dir_q;
        fifo_pop  = took && st == ST_XFER && dir_q;
        irq_set   = st == ST_DONE && ie && !cmd_pend;
    end

    // Sequencer: pending commands first, then descriptor and data steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            dptr     <= '0;
            buf_a    <= '0;
            remain   <= '0;
            ie       <= 1'b0;
            busy_q   <= 1'b0;
            cmd_pend <= 1'b0;
            cmd_go   <= 1'b0;
            dir_q    <= 1'b0;
        end else begin
            busy_q <= mem_req && !mem_ack;
            if (start || stop) begin
                cmd_pend <= 1'b1;
                cmd_go   <= start;
            end else if (apply) begin
                cmd_pend <= 1'b0;
            end
            if (apply) begin
                st    <= cmd_go ? ST_DBUF : ST_IDLE;
                dptr  <= desc_ptr;
                dir_q <= recv;
            end else begin
                case (st)
                    ST_DBUF: if (took) begin
                        buf_a <= mem_rdata[AW-1:0];
                        st    <= ST_DCNT;
                    end
                    ST_DCNT: if (took) begin
                        remain <= mem_rdata[CW-1:0];
                        ie     <= mem_rdata[DESC_IE];
                        st     <= ST_DNXT;
                    end
                    ST_DNXT: if (took) begin
                        dptr <= mem_rdata[AW-1:0];
                        st   <= (remain == '0) ? ST_DONE : ST_XFER;
                    end
                    ST_XFER: if (took) begin
                        buf_a  <= buf_a + AW'(2);
                        remain <= last_hw ? '0 : remain - CW'(2);
                        if (last_hw) st <= ST_DONE;
                    end
                    ST_DONE: st <= ST_DBUF;
                    default: ;
                endcase
            end
        end
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    p_tx_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> lvl9 < {1'b0, hw_mark});
    p_rx_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> lvl9 >= {1'b0, hw_mark});
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        apply && !cmd_go |=> !mem_req);
endmodule

// File: rtl/audio_dma_chan.sv
// Top of the audio DMA channel: register file, descriptor engine, window FIFO.
// Assumes the codec pops in transmit and pushes in receive direction.
module audio_dma_chan #(
    parameter int AW = 16,
    parameter int CW = 14,
    parameter int FIFO_DEPTH = 32,
    localparam int LW = $clog2(FIFO_DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          smp_pop,
    output logic [15:0]   smp_rd_data,
    input  logic          smp_push,
    input  logic [15:0]   smp_wr_data,
    output logic [LW-1:0] smp_level,
    output logic          irq
);
    logic [7:0]    hw_mark, beg_dw, end_dw;
    logic          recv, start, stop, irq_set;
    logic [AW-1:0] desc_ptr, cur_addr;
    logic          eng_push, eng_pop, f_push, f_pop, f_room;
    logic [15:0]   f_wdata, f_rdata;

    // FIFO port steering by direction.
    always_comb begin
        f_push  = recv ? smp_push : eng_push;
        f_wdata = recv ? smp_wr_data : mem_rdata[15:0];
        f_pop   = recv ? eng_pop : smp_pop;
    end
    assign smp_rd_data = f_rdata;

    adma_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .irq_set(irq_set), .cur_addr(cur_addr),
        .rdata(reg_rdata), .hw_mark(hw_mark), .beg_dw(beg_dw),
        .end_dw(end_dw), .recv(recv), .desc_ptr(desc_ptr), .irq(irq),
        .start(start), .stop(stop)
    );

    adma_winfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(start || stop), .beg_dw(beg_dw),
        .end_dw(end_dw), .push(f_push), .wdata(f_wdata), .pop(f_pop),
        .rdata(f_rdata), .level(smp_level), .room(f_room)
    );

    adma_engine #(.AW(AW), .CW(CW), .LW(LW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .desc_ptr(desc_ptr), .recv(recv), .hw_mark(hw_mark),
        .fifo_level(smp_level), .fifo_room(f_room), .fifo_rdata(f_rdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .fifo_push(eng_push), .fifo_pop(eng_pop),
        .irq_set(irq_set), .cur_addr(cur_addr)
    );
endmodule

// File: tb/tb_audio_dma_chan.sv
module tb_audio_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_wide;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        smp_pop = 1'b0, smp_push = 1'b0;
    logic [15:0] smp_rd_data, smp_wr_data = '0;
    logic [5:0]  smp_level;
    logic        irq;

    int checks = 0, failures = 0;
    int rd_cnt = 0, wr_cnt = 0, ack_cnt = 0;
    int rd_log [64];
    logic [15:0] mem16 [4096];
    logic [15:0] txseq [6];
    logic [15:0] rxs [14];

    always #10 clk = ~clk;

    audio_dma_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .smp_pop(smp_pop), .smp_rd_data(smp_rd_data), .smp_push(smp_push),
        .smp_wr_data(smp_wr_data), .smp_level(smp_level), .irq(irq)
    );

    // Memory model: one access at a time, acknowledged the cycle after it is seen.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            ack_cnt++;
            if (mem_we) begin
                mem16[mem_addr[12:1]] <= mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mem_wide ? {mem16[mem_addr[12:1]], mem16[mem_addr[12:1] + 12'd1]}
                                      : {16'h0, mem16[mem_addr[12:1]]};
                if (rd_cnt < 64) rd_log[rd_cnt] = int'(mem_addr);
                rd_cnt++;
            end
        end else mem_ack <= 1'b0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        mem16[a >> 1]       = v[31:16];
        mem16[(a >> 1) + 1] = v[15:0];
    endtask

    // Control word: end[31:24] begin[23:16] mark[15:8] act[4] rt[3] recv[2] load[1].
    function automatic logic [31:0] ctl(input int hw, input int bg, input int en, input bit rx);
        return {8'(en), 8'(bg), 8'(hw), 3'b000, 1'b1, 1'b1, rx, 1'b1, 1'b0};
    endfunction

    // Latest received sample index written to ring slot j after 13 writes.
    function automatic int rx_slot(input int j);
        return 12 - ((12 - j) % 4);
    endfunction

    task automatic pop_n(input int n);
        int got = 0;
        int guard = 0;
        while (got < n && guard < 5000) begin
            @(negedge clk);
            smp_pop = 1'b0;
            guard++;
            if (smp_level != 0 && ($urandom % 2) == 1) begin
                chk("R3/R8 tx order", 32'(smp_rd_data), 32'(txseq[got % 6]));
                smp_pop = 1'b1;
                got++;
            end
        end
        chk("R3 pop count", got, n);
        @(negedge clk);
        smp_pop = 1'b0;
    endtask

    task automatic push_one(input logic [15:0] v);
        @(negedge clk);
        smp_push = 1'b1; smp_wr_data = v;
        @(negedge clk);
        smp_push = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0, a0, w0, seed;
        seed = $urandom(32'd4711);
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        rd_reg(2'd0, v); chk("R1 ctrl", v, 0);
        rd_reg(2'd2, v); chk("R1 bufaddr", v, 0);
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 level", 32'(smp_level), 0);

        for (int i = 0; i < 6; i++) txseq[i] = 16'($urandom);
        for (int i = 0; i < 4; i++) mem16[(16'h400 >> 1) + i] = txseq[i];
        for (int i = 0; i < 2; i++) mem16[(16'h500 >> 1) + i] = txseq[4 + i];
        put32(16'h100, 32'h400); put32(16'h104, 32'h8000_0008); put32(16'h108, 32'h10C);
        put32(16'h10C, 32'h500); put32(16'h110, 32'h4);          put32(16'h114, 32'h100);

        // Transmit with no codec reads: fill to the mark, then stall on desc B.
        r0 = rd_cnt;
        wr_reg(2'd1, 32'h100);
        wr_reg(2'd0, ctl(4, 0, 2, 1'b0));
        tick(100);
        chk("R4 level at mark", 32'(smp_level), 4);
        chk("R4 read total", rd_cnt - r0, 10);
        chk("R2 fetch word0", rd_log[r0], 32'h100);
        chk("R2 fetch word1", rd_log[r0 + 1], 32'h104);
        chk("R2 fetch word2", rd_log[r0 + 2], 32'h108);
        chk("R3 first data addr", rd_log[r0 + 3], 32'h400);
        chk("R2 next desc", rd_log[r0 + 7], 32'h10C);
        chk("R2 next desc word2", rd_log[r0 + 9], 32'h114);
        rd_reg(2'd2, v); chk("R10 buffer address", v, 32'h500);
        chk("R6 irq after ie desc", 32'(irq), 1);
        rd_reg(2'd0, v); chk("R7 status bit", 32'(v[0]), 1);

        // Codec drains at random pace across several ring passes.
        pop_n(30);
        chk("R7 irq held", 32'(irq), 1);

        // Stop with load only.
        wr_reg(2'd0, 32'h2);
        tick(3);
        a0 = ack_cnt;
        tick(60);
        chk("R9 no traffic after stop", ack_cnt, a0);
        rd_reg(2'd0, v); chk("R7 cleared by ctrl write", v, 32'h2);
        chk("R7 irq low", 32'(irq), 0);

        // No interrupt-enable anywhere: restart mid-ring from the first buffer.
        put32(16'h104, 32'h8);
        wr_reg(2'd0, ctl(4, 0, 2, 1'b0));
        pop_n(14);
        tick(5);
        chk("R6 no irq without ie", 32'(irq), 0);
        wr_reg(2'd0, ctl(4, 0, 2, 1'b0));
        pop_n(8);
        wr_reg(2'd0, 32'h2);

        // Mark larger than a one-doubleword window.
        wr_reg(2'd0, ctl(16, 0, 1, 1'b0));
        tick(100);
        chk("R11 level clipped to window", 32'(smp_level), 4);
        a0 = ack_cnt;
        tick(40);
        chk("R11 traffic stops when full", ack_cnt, a0);
        wr_reg(2'd0, 32'h2);

        // Receive into a single-descriptor ring.
        for (int i = 0; i < 4; i++) mem16[(16'h600 >> 1) + i] = 16'h0;
        for (int i = 0; i < 14; i++) rxs[i] = 16'($urandom);
        put32(16'h200, 32'h600); put32(16'h204, 32'h8000_0008); put32(16'h208, 32'h200);
        wr_reg(2'd1, 32'h200);
        w0 = wr_cnt;
        wr_reg(2'd0, ctl(2, 2, 4, 1'b1));
        tick(30);
        push_one(rxs[0]);
        tick(20);
        chk("R5 no write below mark", wr_cnt - w0, 0);
        chk("R5 level one", 32'(smp_level), 1);
        for (int i = 1; i < 5; i++) begin
            tick(4 + int'($urandom % 6));
            push_one(rxs[i]);
        end
        tick(60);
        chk("R5 write count", wr_cnt - w0, 4);
        for (int j = 0; j < 4; j++)
            chk("R5 rx data", 32'(mem16[(16'h600 >> 1) + j]), 32'(rxs[j]));
        chk("R6 rx irq", 32'(irq), 1);
        chk("R5 level left", 32'(smp_level), 1);
        for (int i = 5; i < 14; i++) begin
            tick(4 + int'($urandom % 6));
            push_one(rxs[i]);
        end
        tick(80);
        chk("R8 rx ring writes", wr_cnt - w0, 13);
        for (int j = 0; j < 4; j++)
            chk("R8 rx ring slot", 32'(mem16[(16'h600 >> 1) + j]), 32'(rxs[rx_slot(j)]));
        rd_reg(2'd2, v); chk("R10 rx buffer address", v, 32'h602);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule